// File: doc/BRIEF.md
# Two-Way Inter-Processor Word Mailbox

This block lets two processors, called side A and side B, pass data words to each other. It holds two separate one-way queues. The queue written by A is read by B, and the queue written by B is read by A. Each side has three ports:

- a write-only send port;
- a read-only receive port;
- a 16-bit control/status register.

Each register shows the fill state of both queues. The side's own outgoing queue appears in the low byte. The side's incoming queue appears in the high byte. Through this register a side can see when its partner has drained the words it sent, and when words are waiting for it.

A side switches its own ports on with an enable bit. A send into a full queue and a receive from an empty queue are both reported through a sticky error bit. One interrupt pulse line per side signals two events:

- a word has arrived for that side;
- that side's outgoing queue has just been drained by the partner.

A side can also empty its outgoing queue at once with a command bit. Address decoding and interrupt collection sit outside the block.

Top module: `ipc_mailbox`

## Requirements
- R1: After a synchronous active-low reset, both control registers read 0x0101, both interrupt lines are low, and both receive data outputs are zero.
- R2: Each queue holds DEPTH words (16 by default) in first-in first-out order. Its read and write indices wrap to zero after the last slot, so a long stream keeps its order.
- R3: While a side's bit 15 (enable) is 0, a send from that side is ignored, and a receive by that side returns zero. Neither changes any queue, flag or error bit.
- R4: A send into a full queue drops the word and sets the sender's bit 14 (error). The words already held stay intact and in order.
- R5: A receive from an empty queue returns zero, leaves the queue empty and sets the receiver's bit 14.
- R6: The state of a queue appears to its writer as bit 0 (empty) and bit 1 (full), and to its reader as bit 8 (empty) and bit 9 (full). Both views change in the same cycle.
- R7: Bit 14 stays set until the side writes its control register with bit 14 = 1. Writing it with bit 14 = 0 leaves it set.
- R8: A successful send raises a one-cycle pulse on the receiver's irq in the next cycle, if the receiver's bit 10 is 1.
- R9: A successful receive that leaves a queue empty raises a one-cycle pulse on the writer's irq in the next cycle, if the writer's bit 2 is 1. A receive that leaves words behind raises no pulse.
- R10: Writing the control register with bit 3 = 1 empties that side's outgoing queue, and both sides' flags update to match. Bit 3 always reads 0. A send from the same side in that same cycle is discarded without error.
- R11: Only bits 15, 14 (write-1-to-clear), 10, 3 (command) and 2 respond to writes. Bits 13:11 and 7:3 read 0, and the flag bits 9, 8, 1 and 0 ignore written values.
- R12: A received word appears on the receiver's recv_data in the cycle after the request, and it holds there until that side's next request.
- R13: A send and a receive on the same queue in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_send_valid | input | 1 | Side A pushes a_send_data this cycle |
| a_send_data | input | DATA_W | Word sent by side A |
| a_recv_req | input | 1 | Side A pops a word from its incoming queue |
| a_recv_data | output | DATA_W | Word received by side A, registered |
| a_ctl_we | input | 1 | Write strobe for side A's control register |
| a_ctl_wdata | input | 16 | Write data for side A's control register |
| a_ctl_rdata | output | 16 | Side A's control/status view |
| a_irq | output | 1 | Interrupt pulse toward side A |
| b_send_valid | input | 1 | Side B pushes b_send_data this cycle |
| b_send_data | input | DATA_W | Word sent by side B |
| b_recv_req | input | 1 | Side B pops a word from its incoming queue |
| b_recv_data | output | DATA_W | Word received by side B, registered |
| b_ctl_we | input | 1 | Write strobe for side B's control register |
| b_ctl_wdata | input | 16 | Write data for side B's control register |
| b_ctl_rdata | output | 16 | Side B's control/status view |
| b_irq | output | 1 | Interrupt pulse toward side B |

## Verification
The bench builds the block with its defaults, DATA_W = 32 and DEPTH = 16. With 16 slots, a full queue and the overflow drop take only a short burst of sends. The index wrap comes within reach after a few dozen words, so the order check covers several passes over both indices. The 32-bit width lets each test word carry a distinct tag, so a dropped or reordered word shows directly in the received value.

// File: rtl/ipc_mbox_pkg.sv
// Package: shared control-register bit positions and per-side control state
// for the two-way mailbox. Assumes a 16-bit control register.
package ipc_mbox_pkg;
    localparam int CTL_W      = 16;
    localparam int B_TX_EMPTY = 0;
    localparam int B_TX_FULL  = 1;
    localparam int B_TX_IEN   = 2;
    localparam int B_FLUSH    = 3;
    localparam int B_RX_EMPTY = 8;
    localparam int B_RX_FULL  = 9;
    localparam int B_RX_IEN   = 10;
    localparam int B_ERR      = 14;
    localparam int B_EN       = 15;

    typedef struct packed {
        logic en;
        logic err;
        logic ien_rx;
        logic ien_tx;
    } ctl_state_t;
endpackage

// File: rtl/ipc_queue.sv
// Module: one-way first-in first-out word queue with a wrapping read index
// and a wrapping write index, plus an occupancy count.
// Assumes: the caller gates push and pop with the enables; flush has priority
// over push; a pop in the flush cycle still returns the head word.
module ipc_queue #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              push_ok,
    output logic              pop_ok,
    output logic              empty,
    output logic              full,
    output logic              drained
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Accept and completion qualifiers
    always_comb begin
        empty     = (count == '0);
        full      = (count == FULL_CNT);
        push_ok   = push & ~full & ~flush;
        pop_ok    = pop & ~empty;
        drained   = pop_ok & ~push_ok & ~flush & (count == CNT_W'(1));
        head_data = mem[rd_ptr];
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Index and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/ipc_ctl_reg.sv
// Module: one side's control/status register. It holds the enable, the
// sticky error and the two interrupt enables, and it composes the read view
// from the live flags of both queues.
// Assumes: set_err wins over a write-1-to-clear in the same cycle.
module ipc_ctl_reg
    import ipc_mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    input  logic             set_err,
    input  logic             tx_empty,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic             rx_full,
    output ctl_state_t       st,
    output logic             flush,
    output logic [CTL_W-1:0] rdata
);
    // Writable state and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '0;
        end else begin
            if (we) begin
                st.en     <= wdata[B_EN];
                st.ien_rx <= wdata[B_RX_IEN];
                st.ien_tx <= wdata[B_TX_IEN];
            end
            if (set_err)                 st.err <= 1'b1;
            else if (we && wdata[B_ERR]) st.err <= 1'b0;
        end
    end

    // Clear-queue command strobe
    assign flush = we & wdata[B_FLUSH];

    // Read view
    always_comb begin
        rdata             = '0;
        rdata[B_EN]       = st.en;
        rdata[B_ERR]      = st.err;
        rdata[B_RX_IEN]   = st.ien_rx;
        rdata[B_RX_FULL]  = rx_full;
        rdata[B_RX_EMPTY] = rx_empty;
        rdata[B_TX_IEN]   = st.ien_tx;
        rdata[B_TX_FULL]  = tx_full;
        rdata[B_TX_EMPTY] = tx_empty;
    end
endmodule

// File: rtl/ipc_irq_gen.sv
// Module: one side's interrupt pulse. It fires one cycle after a word
// arrives for this side or after this side's outgoing queue drains, each
// cause qualified by its own enable.
module ipc_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic ien_arrive,
    input  logic drain,
    input  logic ien_drain,
    output logic irq
);
    // Registered pulse
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (arrive & ien_arrive) | (drain & ien_drain);
    end
endmodule

// File: rtl/ipc_mailbox.sv
// Module: two-way mailbox top. Queue g is written by side g and read by the
// other side. Each side has a control register, a registered receive output
// and an interrupt line. Side 0 is A and side 1 is B.
// Assumes: DEPTH >= 2; the control write and the data ports of a side are
// sampled in the same clock; enables gate only that side's own ports.
module ipc_mailbox
    import ipc_mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_send_valid,
    input  logic [DATA_W-1:0] a_send_data,
    input  logic              a_recv_req,
    output logic [DATA_W-1:0] a_recv_data,
    input  logic              a_ctl_we,
    input  logic [CTL_W-1:0]  a_ctl_wdata,
    output logic [CTL_W-1:0]  a_ctl_rdata,
    output logic              a_irq,
    input  logic              b_send_valid,
    input  logic [DATA_W-1:0] b_send_data,
    input  logic              b_recv_req,
    output logic [DATA_W-1:0] b_recv_data,
    input  logic              b_ctl_we,
    input  logic [CTL_W-1:0]  b_ctl_wdata,
    output logic [CTL_W-1:0]  b_ctl_rdata,
    output logic              b_irq
);
    localparam int SIDES = 2;

    logic [SIDES-1:0] send_v, recv_r, ctl_we, flush, irq;
    logic [SIDES-1:0] push_ok, pop_ok, q_empty, q_full, drained;
    logic [SIDES-1:0] err_tx, err_rx;
    logic [DATA_W-1:0] send_d [SIDES];
    logic [DATA_W-1:0] head   [SIDES];
    logic [DATA_W-1:0] rdat   [SIDES];
    logic [CTL_W-1:0]  ctl_wd [SIDES];
    logic [CTL_W-1:0]  ctl_rd [SIDES];
    ctl_state_t        st     [SIDES];

    // Port-to-array mapping
    always_comb begin
        send_v    = {b_send_valid, a_send_valid};
        recv_r    = {b_recv_req, a_recv_req};
        ctl_we    = {b_ctl_we, a_ctl_we};
        send_d[0] = a_send_data;
        send_d[1] = b_send_data;
        ctl_wd[0] = a_ctl_wdata;
        ctl_wd[1] = b_ctl_wdata;
    end

    assign a_recv_data = rdat[0];
    assign b_recv_data = rdat[1];
    assign a_ctl_rdata = ctl_rd[0];
    assign b_ctl_rdata = ctl_rd[1];
    assign a_irq       = irq[0];
    assign b_irq       = irq[1];

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        localparam int P = SIDES - 1 - g;

        // Error causes seen by this side
        assign err_tx[g] = send_v[g] & st[g].en & q_full[g] & ~flush[g];
        assign err_rx[g] = recv_r[g] & st[g].en & q_empty[P];

        ipc_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (flush[g]),
            .push      (send_v[g] & st[g].en),
            .push_data (send_d[g]),
            .pop       (recv_r[P] & st[P].en),
            .head_data (head[g]),
            .push_ok   (push_ok[g]),
            .pop_ok    (pop_ok[g]),
            .empty     (q_empty[g]),
            .full      (q_full[g]),
            .drained   (drained[g])
        );

        ipc_ctl_reg u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (ctl_we[g]),
            .wdata    (ctl_wd[g]),
            .set_err  (err_tx[g] | err_rx[g]),
            .tx_empty (q_empty[g]),
            .tx_full  (q_full[g]),
            .rx_empty (q_empty[P]),
            .rx_full  (q_full[P]),
            .st       (st[g]),
            .flush    (flush[g]),
            .rdata    (ctl_rd[g])
        );

        ipc_irq_gen u_irq (
            .clk        (clk),
            .rst_n      (rst_n),
            .arrive     (push_ok[P]),
            .ien_arrive (st[g].ien_rx),
            .drain      (drained[g]),
            .ien_drain  (st[g].ien_tx),
            .irq        (irq[g])
        );

        // Receive data register: head word on success, zero otherwise
        always_ff @(posedge clk) begin
            if (!rst_n)         rdat[g] <= '0;
            else if (recv_r[g]) rdat[g] <= pop_ok[P] ? head[P] : '0;
        end
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
// Checker: port-level properties of the mailbox, attached by bind.
module ipc_mailbox_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_send_valid,
    input logic              a_ctl_we,
    input logic [15:0]       a_ctl_wdata,
    input logic [15:0]       a_ctl_rdata,
    input logic              b_recv_req,
    input logic [DATA_W-1:0] b_recv_data,
    input logic [15:0]       b_ctl_rdata,
    input logic              b_irq
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_ctl_rdata[0] && a_ctl_rdata[1]) && !(b_ctl_rdata[8] && b_ctl_rdata[9])); // R6

    AST_DISABLED_SEND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        a_send_valid && !a_ctl_rdata[15] && !a_ctl_we && !b_recv_req
        |=> $stable(a_ctl_rdata[1:0]) && $stable(a_ctl_rdata[14])); // R3

    AST_OVERFLOW_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        a_send_valid && a_ctl_rdata[15] && a_ctl_rdata[1] && !a_ctl_we |=> a_ctl_rdata[14]); // R4

    AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        b_recv_req && b_ctl_rdata[8] |=> b_recv_data == '0); // R5

    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        a_ctl_rdata[14] && !(a_ctl_we && a_ctl_wdata[14]) |=> a_ctl_rdata[14]); // R7

    AST_ARRIVAL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        a_send_valid && a_ctl_rdata[15] && !a_ctl_rdata[1] && !a_ctl_we && b_ctl_rdata[10]
        |=> b_irq); // R8
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ipc_mailbox.sv
// Directed bench for the two-way mailbox: one task per scenario.
module sim_ipc_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_send_valid = 1'b0, b_send_valid = 1'b0;
    logic [31:0] a_send_data = '0, b_send_data = '0;
    logic        a_recv_req = 1'b0, b_recv_req = 1'b0;
    logic [31:0] a_recv_data, b_recv_data;
    logic        a_ctl_we = 1'b0, b_ctl_we = 1'b0;
    logic [15:0] a_ctl_wdata = '0, b_ctl_wdata = '0;
    logic [15:0] a_ctl_rdata, b_ctl_rdata;
    logic        a_irq, b_irq;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ctl(input int s);
        return (s == 0) ? a_ctl_rdata : b_ctl_rdata;
    endfunction

    task automatic send(input int s, input logic [31:0] d);
        @(negedge clk);
        if (s == 0) begin a_send_valid = 1'b1; a_send_data = d; end
        else        begin b_send_valid = 1'b1; b_send_data = d; end
        @(negedge clk);
        a_send_valid = 1'b0; b_send_valid = 1'b0;
    endtask

    task automatic recv(input int s, output logic [31:0] d);
        @(negedge clk);
        if (s == 0) a_recv_req = 1'b1; else b_recv_req = 1'b1;
        @(negedge clk);
        a_recv_req = 1'b0; b_recv_req = 1'b0;
        d = (s == 0) ? a_recv_data : b_recv_data;
    endtask

    task automatic wctl(input int s, input logic [15:0] v);
        @(negedge clk);
        if (s == 0) begin a_ctl_we = 1'b1; a_ctl_wdata = v; end
        else        begin b_ctl_we = 1'b1; b_ctl_wdata = v; end
        @(negedge clk);
        a_ctl_we = 1'b0; b_ctl_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 a ctl", 32'(a_ctl_rdata), 32'h0101);
        chk("R1 b ctl", 32'(b_ctl_rdata), 32'h0101);
        chk("R1 irqs", {30'd0, a_irq, b_irq}, 0);
        chk("R1 recv", a_recv_data | b_recv_data, 0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        send(0, 32'h11);
        chk("R3 disabled send", 32'(b_ctl_rdata[8]), 1);
        chk("R3 disabled send err", 32'(a_ctl_rdata[14]), 0);
        wctl(0, 16'h8000);
        send(0, 32'h55);
        recv(1, d);
        chk("R3 disabled recv data", d, 0);
        chk("R3 disabled recv keeps word", 32'(a_ctl_rdata[0]), 0);
        chk("R3 disabled recv no err", 32'(b_ctl_rdata[14]), 0);
        wctl(1, 16'h8000);
        recv(1, d);
        chk("R3 word after enable", d, 32'h55);
    endtask

    task automatic t_writable();
        wctl(0, 16'hFFFF);
        chk("R11 write all ones", 32'(a_ctl_rdata), 32'h8505);
        wctl(0, 16'h8000);
        chk("R11 restore", 32'(a_ctl_rdata), 32'h8101);
    endtask

    task automatic t_order();
        logic [31:0] d;
        for (int i = 0; i < 3; i++) send(0, 32'hA00 + i);
        chk("R8 no irq when disabled", 32'(b_irq), 0);
        chk("R6 writer empty", 32'(a_ctl_rdata[1:0]), 0);
        chk("R6 reader empty", 32'(b_ctl_rdata[9:8]), 0);
        for (int i = 0; i < 3; i++) begin
            recv(1, d);
            chk("R2 order", d, 32'hA00 + i);
        end
        chk("R6 writer empty again", 32'(a_ctl_rdata[1:0]), 1);
        chk("R6 reader empty again", 32'(b_ctl_rdata[9:8]), 1);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 16; i++) send(0, 32'h100 + i);
        chk("R6 writer full", 32'(a_ctl_rdata[1:0]), 2);
        chk("R6 reader full", 32'(b_ctl_rdata[9:8]), 2);
        send(0, 32'hDEAD);
        chk("R4 sender error", 32'(a_ctl_rdata[14]), 1);
        chk("R4 receiver no error", 32'(b_ctl_rdata[14]), 0);
        for (int i = 0; i < 16; i++) begin
            recv(1, d);
            chk("R4 held words intact", d, 32'h100 + i);
            if (i == 0) chk("R6 full cleared", 32'(a_ctl_rdata[1]), 0);
        end
        chk("R6 empty after drain", 32'(a_ctl_rdata[0]), 1);
    endtask

    task automatic t_errclr();
        wctl(0, 16'h8000);
        chk("R7 write 0 keeps error", 32'(a_ctl_rdata[14]), 1);
        wctl(0, 16'hC000);
        chk("R7 write 1 clears error", 32'(a_ctl_rdata[14]), 0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 11; i++) send(0, 32'h2000 + r * 16 + i);
            for (int i = 0; i < 11; i++) begin
                recv(1, d);
                chk("R2 wrap order", d, 32'h2000 + r * 16 + i);
            end
        end
    endtask

    task automatic t_underflow();
        logic [31:0] d;
        recv(1, d);
        chk("R5 data zero", d, 0);
        chk("R5 error", 32'(b_ctl_rdata[14]), 1);
        chk("R5 still empty", 32'(b_ctl_rdata[9:8]), 1);
        wctl(1, 16'hC000);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        send(0, 32'h77);
        recv(1, d);
        chk("R12 data", d, 32'h77);
        repeat (3) @(negedge clk);
        chk("R12 hold", b_recv_data, 32'h77);
    endtask

    task automatic t_irq_rx();
        logic [31:0] d;
        wctl(1, 16'h8400);
        send(0, 32'hA1);
        chk("R8 receiver pulse", 32'(b_irq), 1);
        chk("R8 sender quiet", 32'(a_irq), 0);
        @(negedge clk);
        chk("R8 pulse ends", 32'(b_irq), 0);
        recv(1, d);
        wctl(1, 16'h8000);
    endtask

    task automatic t_irq_drain();
        logic [31:0] d;
        wctl(0, 16'h8004);
        send(0, 32'h1);
        send(0, 32'h2);
        recv(1, d);
        chk("R9 no pulse while words remain", 32'(a_irq), 0);
        recv(1, d);
        chk("R9 drain pulse", 32'(a_irq), 1);
        @(negedge clk);
        chk("R9 pulse ends", 32'(a_irq), 0);
        wctl(0, 16'h8000);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) send(0, 32'h300 + i);
        wctl(0, 16'h8008);
        chk("R10 writer empty", 32'(a_ctl_rdata[0]), 1);
        chk("R10 reader empty", 32'(b_ctl_rdata[8]), 1);
        chk("R10 bit3 reads 0", 32'(a_ctl_rdata[3]), 0);
        recv(1, d);
        chk("R10 nothing left", d, 0);
        wctl(1, 16'hC000);
        @(negedge clk);
        a_send_valid = 1'b1; a_send_data = 32'h999;
        a_ctl_we = 1'b1; a_ctl_wdata = 16'h8008;
        @(negedge clk);
        a_send_valid = 1'b0; a_ctl_we = 1'b0;
        chk("R10 same-cycle send discarded", 32'(a_ctl_rdata[0]), 1);
        chk("R10 same-cycle no error", 32'(a_ctl_rdata[14]), 0);
    endtask

    task automatic t_simul();
        logic [31:0] d;
        send(0, 32'hC0);
        @(negedge clk);
        a_send_valid = 1'b1; a_send_data = 32'hC1; b_recv_req = 1'b1;
        @(negedge clk);
        a_send_valid = 1'b0; b_recv_req = 1'b0;
        chk("R13 popped head", b_recv_data, 32'hC0);
        chk("R13 pushed word kept", 32'(b_ctl_rdata[8]), 0);
        recv(1, d);
        chk("R13 second word", d, 32'hC1);
        chk("R13 empty", 32'(b_ctl_rdata[8]), 1);
        send(1, 32'hB0B0);
        chk("R6 B writer view", 32'(b_ctl_rdata[1:0]), 0);
        chk("R6 A reader view", 32'(a_ctl_rdata[9:8]), 0);
        recv(0, d);
        chk("R2 B to A word", d, 32'hB0B0);
        chk("R6 A reader empty", 32'(a_ctl_rdata[8]), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_writable();
        t_order();
        t_full();
        t_errclr();
        t_wrap();
        t_underflow();
        t_hold();
        t_irq_rx();
        t_irq_drain();
        t_clear();
        t_simul();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule